// File: doc/BRIEF.md
# SHA-2 Message Padding Sequencer

This block sits between a message-word FIFO and a SHA-2 compression engine and appends standard SHA-2 padding as the words stream through. A message begins with a start pulse that carries the digest mode and the total message length in bits. Full message words then pass straight from the FIFO to the engine. After the last full word, the block emits one marker word, in which the 0x80 byte follows the leftover message bytes of a trailing partial word. It then sends zero words up to the length slot of the current block, and then the bit length as two halves, after which it returns to idle.

Both digest families use a 16-word block. In the 256-bit mode a word carries 32 message bits, placed in the low half of the 64-bit output with the high half zero. In the 384- and 512-bit modes a word carries the full 64 bits. The length always occupies words 14 and 15 of a block. Once the message words are done the output is valid in every cycle until the length has been sent. A start request with an illegal mode code produces an error pulse and no output.

Top module: `sha2pad_engine`

## Requirements
- R1: During and right after reset the block is idle: `out_valid_o`, `in_ready_o` and `err_o` are 0.
- R2: The mode code is 2'b00 = 256-bit, 2'b01 = 384-bit, 2'b10 = 512-bit. If `start_i` arrives with `mode_i` = 2'b11 while enabled and idle, `err_o` is high for exactly one cycle (the cycle after the start), no word is produced and the block stays idle.
- R3: A `start_i` that arrives while `enable_i` is 0 in idle is ignored: `in_ready_o` and `out_valid_o` stay 0 even with input offered.
- R4: While message words flow, `out_valid_o` follows `in_valid_i` and `in_ready_o` follows `out_ready_i`. Each full word is forwarded unchanged in the 384/512 modes. In the 256-bit mode the output is {32'h0, in_data_i[31:0]}. The number of full words is length/32 (256-bit mode) or length/64 (other modes).
- R5: 256-bit mode, marker word selected by length bits [4:3] (k leftover bytes, taken from the top of in_data_i[31:0]): 00 gives 64'h0000_0000_8000_0000; 01 gives the top byte then 24'h800000; 10 gives the top two bytes then 16'h8000; 11 gives the top three bytes then 8'h80. The upper 32 bits are zero.
- R6: 384/512 modes: with k = length bits [5:3], the marker word is the top k bytes of in_data_i, then the byte 0x80, then zero bytes.
- R7: After the marker, zero words follow until the next word position (counted from the first word of the message, modulo 16) is 14. A marker at position 14 or 15 therefore pushes the length into a further block.
- R8: Word 14 carries the upper length half and word 15 the lower half. In 256-bit mode these are {32'h0, len[63:32]} and {32'h0, len[31:0]}. In the other modes they are 64'h0 and len[63:0]. After the lower half the block is idle again.
- R9: From the marker word until the lower length half is accepted, `out_valid_o` is 1 in every cycle, including cycles with `out_ready_i` low.
- R10: The marker word consumes one input word only when leftover bytes exist (k != 0). Otherwise `in_ready_o` stays 0 while the marker is on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Core enable; start requests are honoured only when high |
| start_i | input | 1 | Start of a message (one-cycle pulse) |
| mode_i | input | 2 | Digest mode code sampled with start |
| len_i | input | 64 | Message length in bits, sampled with start |
| in_valid_i | input | 1 | FIFO word valid |
| in_data_i | input | 64 | FIFO word |
| in_ready_o | output | 1 | FIFO word accepted when high with valid |
| out_valid_o | output | 1 | Word to engine valid |
| out_data_o | output | 64 | Word to engine |
| out_ready_i | input | 1 | Engine accepts word |
| err_o | output | 1 | Illegal mode pulse |

## Verification
The checker assumes the FIFO already holds the trailing partial word when the marker is due. The marker reads `in_data_i` in that cycle with no stall path on the input side. It also assumes lengths are whole bytes, so length bits [2:0] are zero. The bench keeps to both: it offers each message word as soon as the previous one is taken, so the partial word is on the input when the block enters the marker state, and every length used is a multiple of 8. Downstream back-pressure is still applied in both the pass-through and tail phases. The aim is to show that the output stays valid and that no word is lost or repeated.

// File: rtl/sha2pad_pkg.sv
package sha2pad_pkg;

    parameter int WORD_W    = 64;
    parameter int LEN_W     = 64;
    parameter int BLK_WORDS = 16;

    localparam int HALF_W     = WORD_W / 2;
    localparam int POS_W      = $clog2(BLK_WORDS);
    localparam int LEN_SLOT   = BLK_WORDS - 2;
    localparam int BYTES_W    = WORD_W / 8;
    localparam int NARROW_SH  = $clog2(HALF_W);
    localparam int WIDE_SH    = $clog2(WORD_W);

    localparam logic [1:0] MODE_256 = 2'b00;
    localparam logic [1:0] MODE_384 = 2'b01;
    localparam logic [1:0] MODE_512 = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RECV  = 3'd1,
        ST_MARK  = 3'd2,
        ST_ZERO  = 3'd3,
        ST_LENHI = 3'd4,
        ST_LENLO = 3'd5
    } pad_state_e;

    typedef struct packed {
        logic             narrow;
        logic [LEN_W-1:0] bits;
    } job_t;

    function automatic logic mode_legal(input logic [1:0] m);
        return (m == MODE_256) || (m == MODE_384) || (m == MODE_512);
    endfunction

endpackage

// File: rtl/sha2pad_ctrl.sv
module sha2pad_ctrl
    import sha2pad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             in_valid_i,
    input  logic             out_ready_i,
    output pad_state_e       state_o,
    output job_t             job_o,
    output logic [2:0]       kbytes_o,
    output logic [POS_W-1:0] pos_o,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output logic             err_o
);

    pad_state_e       st_q, st_d;
    job_t             job_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] nfull;
    logic [POS_W-1:0] pos_nxt;
    logic             adv;
    logic             err_q;
    logic             take;

    assign take    = (st_q == ST_IDLE) && start_i && enable_i;
    assign nfull   = job_q.narrow ? (job_q.bits >> NARROW_SH) : (job_q.bits >> WIDE_SH);
    assign kbytes_o = job_q.narrow ? {1'b0, job_q.bits[NARROW_SH-1:3]} : job_q.bits[WIDE_SH-1:3];
    assign pos_o   = cnt_q[POS_W-1:0];
    assign pos_nxt = pos_o + 1'b1;

    always_comb begin
        st_d        = st_q;
        out_valid_o = 1'b0;
        in_ready_o  = 1'b0;
        adv         = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (take && mode_legal(mode_i)) st_d = ST_RECV;
            end
            ST_RECV: begin
                if (cnt_q == nfull) begin
                    st_d = ST_MARK;
                end else begin
                    out_valid_o = in_valid_i;
                    in_ready_o  = out_ready_i;
                    adv         = in_valid_i && out_ready_i;
                end
            end
            ST_MARK, ST_ZERO: begin
                out_valid_o = 1'b1;
                in_ready_o  = out_ready_i && (st_q == ST_MARK) && (kbytes_o != 3'd0);
                if (out_ready_i) begin
                    adv  = 1'b1;
                    st_d = (pos_nxt == POS_W'(LEN_SLOT)) ? ST_LENHI : ST_ZERO;
                end
            end
            ST_LENHI: begin
                out_valid_o = 1'b1;
                if (out_ready_i) begin
                    adv  = 1'b1;
                    st_d = ST_LENLO;
                end
            end
            ST_LENLO: begin
                out_valid_o = 1'b1;
                if (out_ready_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            job_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= take && !mode_legal(mode_i);
            if (take && mode_legal(mode_i)) begin
                cnt_q        <= '0;
                job_q.narrow <= (mode_i == MODE_256);
                job_q.bits   <= len_i;
            end else if (adv) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign state_o = st_q;
    assign job_o   = job_q;
    assign err_o   = err_q;

endmodule

// File: rtl/sha2pad_word.sv
module sha2pad_word
    import sha2pad_pkg::*;
(
    input  pad_state_e        state_i,
    input  job_t              job_i,
    input  logic [2:0]        kbytes_i,
    input  logic [WORD_W-1:0] in_data_i,
    output logic [WORD_W-1:0] out_data_o
);

    logic [HALF_W-1:0] mark_n;
    logic [WORD_W-1:0] mark_w;
    logic [HALF_W-1:0] lo_half;

    assign lo_half = in_data_i[HALF_W-1:0];

    always_comb begin
        unique case (kbytes_i[1:0])
            2'b01:   mark_n = {lo_half[HALF_W-1 -: 8],  24'h80_0000};
            2'b10:   mark_n = {lo_half[HALF_W-1 -: 16], 16'h8000};
            2'b11:   mark_n = {lo_half[HALF_W-1 -: 24], 8'h80};
            default: mark_n = 32'h8000_0000;
        endcase
    end

    for (genvar b = 0; b < BYTES_W; b++) begin : g_mbyte
        localparam int HI = WORD_W - 1 - 8 * b;
        assign mark_w[HI -: 8] = (b < int'(kbytes_i)) ? in_data_i[HI -: 8] :
                                 (b == int'(kbytes_i)) ? 8'h80 : 8'h00;
    end

    always_comb begin
        unique case (state_i)
            ST_RECV:  out_data_o = job_i.narrow ? {{HALF_W{1'b0}}, lo_half} : in_data_i;
            ST_MARK:  out_data_o = job_i.narrow ? {{HALF_W{1'b0}}, mark_n} : mark_w;
            ST_LENHI: out_data_o = job_i.narrow ?
                                   {{HALF_W{1'b0}}, job_i.bits[LEN_W-1 -: HALF_W]} : '0;
            ST_LENLO: out_data_o = job_i.narrow ?
                                   {{HALF_W{1'b0}}, job_i.bits[HALF_W-1:0]} : job_i.bits;
            default:  out_data_o = '0;
        endcase
    end

endmodule

// File: rtl/sha2pad_engine.sv
module sha2pad_engine
    import sha2pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              in_valid_i,
    input  logic [WORD_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              err_o
);

    pad_state_e       state;
    job_t             job;
    logic [2:0]       kbytes;
    logic [POS_W-1:0] pos;

    sha2pad_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .len_i       (len_i),
        .in_valid_i  (in_valid_i),
        .out_ready_i (out_ready_i),
        .state_o     (state),
        .job_o       (job),
        .kbytes_o    (kbytes),
        .pos_o       (pos),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .err_o       (err_o)
    );

    sha2pad_word u_word (
        .state_i    (state),
        .job_i      (job),
        .kbytes_i   (kbytes),
        .in_data_i  (in_data_i),
        .out_data_o (out_data_o)
    );

endmodule

// File: rtl/sha2pad_checker.sv
module sha2pad_checker
    import sha2pad_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic             err_o,
    input pad_state_e       state,
    input logic [2:0]       kbytes,
    input logic [POS_W-1:0] pos
);

    a_r2_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    a_r2_err_silent: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (state == ST_IDLE) && !out_valid_o);

    a_r3_disabled_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !enable_i) |=> state == ST_IDLE);

    a_r4_ready_follow: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV && in_ready_o) |-> out_ready_i);

    a_r7_lenhi_pos: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LENHI) |-> pos == POS_W'(LEN_SLOT));

    a_r7_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ZERO && !out_ready_i) |=> state == ST_ZERO);

    a_r8_lenlo_exit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LENLO && out_ready_i) |=> state == ST_IDLE);

    a_r9_tail_valid: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MARK || state == ST_ZERO || state == ST_LENHI || state == ST_LENLO)
        |-> out_valid_o);

    a_r10_no_take: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MARK && kbytes == 3'd0) |-> !in_ready_o);

endmodule

bind sha2pad_engine sha2pad_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable_i    (enable_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .err_o       (err_o),
    .state       (state),
    .kbytes      (kbytes),
    .pos         (pos)
);

// File: tb/tb_sha2pad_engine.sv
`timescale 1ns/1ps
module tb_sha2pad_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [63:0] len_i = '0;
    logic        in_valid_i = 1'b0;
    logic [63:0] in_data_i = '0;
    logic        in_ready_o;
    logic        out_valid_o;
    logic [63:0] out_data_o;
    logic        out_ready_i = 1'b1;
    logic        err_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit stall_en = 1'b0;
    bit in_tail  = 1'b0;

    typedef struct {
        logic [63:0] data;
        int          kind;
        string       tag;
    } item_t;

    item_t expq[$];

    always #5 clk = ~clk;

    sha2pad_engine dut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .start_i(start_i),
        .mode_i(mode_i), .len_i(len_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
        .out_data_o(out_data_o), .out_ready_i(out_ready_i), .err_o(err_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1 out_ready_i = !(stall_en && (cyc % 5 == 3));
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (in_tail && !out_ready_i)
                check(out_valid_o == 1'b1, "R9 tail valid under stall", 64'(out_valid_o), 64'd1);
            if (out_valid_o && out_ready_i) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R8 unexpected extra word", out_data_o, 64'h0);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    check(out_data_o === it.data, it.tag, out_data_o, it.data);
                    if (it.kind == 1) in_tail = 1'b1;
                    if (it.kind == 4) in_tail = 1'b0;
                end
            end
        end
    end

    function automatic logic [63:0] msg_word(input int m, input int i);
        return {32'hC0DE_0000 | 32'(m << 8) | 32'(i), 32'h1234_0000 | 32'(m << 8) | 32'(i)};
    endfunction

    function automatic logic [63:0] exp_mark(input bit narrow, input int k,
                                             input logic [63:0] d);
        logic [31:0] m32;
        logic [63:0] m64;
        if (narrow) begin
            m32 = (k == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - 8 * k));
            return {32'h0, (d[31:0] & m32) | (32'h80 << (24 - 8 * k))};
        end
        m64 = (k == 0) ? 64'h0 : (64'hFFFF_FFFF_FFFF_FFFF << (64 - 8 * k));
        return (d & m64) | (64'h80 << (56 - 8 * k));
    endfunction

    task automatic push(input logic [63:0] d, input int kind, input string tag);
        item_t it;
        it.data = d;
        it.kind = kind;
        it.tag  = tag;
        expq.push_back(it);
    endtask

    task automatic send_msg(input logic [1:0] mode, input logic [63:0] len, input int m);
        bit narrow = (mode == 2'b00);
        int wb     = narrow ? 32 : 64;
        int nfull  = int'(len) / wb;
        int k      = (int'(len) % wb) / 8;
        int nwords = nfull + ((k != 0) ? 1 : 0);
        int pos    = 0;
        for (int i = 0; i < nfull; i++) begin
            logic [63:0] w = msg_word(m, i);
            push(narrow ? {32'h0, w[31:0]} : w, 0, "R4 pass-through word");
            pos++;
        end
        push(exp_mark(narrow, k, msg_word(m, nfull)), 1,
             narrow ? "R5 narrow marker word" : "R6 wide marker word");
        pos++;
        while (pos % 16 != 14) begin
            push(64'h0, 2, "R7 zero fill");
            pos++;
        end
        push(narrow ? {32'h0, len[63:32]} : 64'h0, 3, "R8 length upper half");
        push(narrow ? {32'h0, len[31:0]} : len, 4, "R8 length lower half");

        @(posedge clk); #1;
        start_i = 1'b1; mode_i = mode; len_i = len;
        @(posedge clk); #1;
        start_i = 1'b0;
        for (int i = 0; i < nwords; i++) begin
            in_valid_i = 1'b1;
            in_data_i  = msg_word(m, i);
            do @(negedge clk); while (!in_ready_o);
            @(posedge clk); #1;
        end
        in_valid_i = 1'b0;
        for (int t = 0; t < 500; t++) begin
            @(negedge clk); #1;
            if (expq.size() == 0) break;
        end
        check(expq.size() == 0, "R8 all expected words seen", 64'(expq.size()), 64'd0);
        @(negedge clk);
        check(!out_valid_o && !in_ready_o, "R8 back to idle",
              {in_ready_o, out_valid_o}, 64'h0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid_o && !in_ready_o && !err_o, "R1 reset quiet",
              {err_o, in_ready_o, out_valid_o}, 64'h0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid_o && !in_ready_o && !err_o, "R1 idle after reset",
              {err_o, in_ready_o, out_valid_o}, 64'h0);

        // R3: start while disabled is ignored
        @(posedge clk); #1;
        start_i = 1'b1; mode_i = 2'b00; len_i = 64'd64;
        in_valid_i = 1'b1; in_data_i = 64'hDEAD_BEEF_0000_0001;
        @(posedge clk); #1 start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!in_ready_o && !out_valid_o, "R3 disabled start ignored",
                  {in_ready_o, out_valid_o}, 64'h0);
        end
        @(posedge clk); #1 in_valid_i = 1'b0; enable_i = 1'b1;

        // R2: illegal mode raises a one-cycle error
        @(posedge clk); #1;
        start_i = 1'b1; mode_i = 2'b11; len_i = 64'd96;
        @(posedge clk); #1 start_i = 1'b0;
        @(negedge clk);
        check(err_o == 1'b1, "R2 error raised", 64'(err_o), 64'd1);
        check(!out_valid_o && !in_ready_o, "R2 no output on error",
              {in_ready_o, out_valid_o}, 64'h0);
        @(negedge clk);
        check(err_o == 1'b0, "R2 error is a pulse", 64'(err_o), 64'd0);

        send_msg(2'b00, 64'd0, 1);                 // R5 k=0, empty message
        send_msg(2'b00, 64'd104, 2);               // R5 k=1
        send_msg(2'b00, 64'd432, 3);               // R5 k=2, marker at slot 13
        send_msg(2'b00, 64'd472, 4);               // R5 k=3, marker at slot 14 -> R7 extra block
        stall_en = 1'b1;
        send_msg(2'b10, 64'd232, 5);               // R6 k=5 with back-pressure
        send_msg(2'b01, 64'd960, 6);               // R6 k=0, marker at slot 15
        send_msg(2'b00, 64'd64, 7);                // R4 narrow with back-pressure
        stall_en = 1'b0;
        send_msg(2'b10, 64'd184, 8);               // R6 k=7, R10 partial consumed

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule